// File: doc/BRIEF.md
# Two-Bank Latching Interrupt Controller

This block gathers up to 64 interrupt sources into two banks of 32 and drives one request line towards a processor. Each bank has four 32-bit registers on a small synchronous register bus. The event register holds latched edges. The enable register gates each source. Writing ones to the acknowledge register clears latched events. The raw-state register shows the inputs as they are now. Source n belongs to bank n>>5 and occupies bit n&31 of that bank's registers. Data bit i on the bus is register bit i (little-endian lane order).

Each source is either edge-type or level-type, chosen per bank by a mask parameter. An edge-type source latches an event when its input rises while it is enabled. Enabling a source whose input is already high therefore raises nothing. A level-type source is reported from its live input, so acknowledging its latch does not clear it while the input stays high. A helper output names the highest-numbered pending source, so the handler needs no scan. The upper bank is searched before the lower one.

Inputs are taken as synchronous to `clk`. The block has no state machine. It is built from an address decoder, two bank register slices and a priority finder.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset all enable and event bits are zero, `irq_req` and `top_valid` are low, and `bus_rdata` is zero.
- R2: Bank 0 occupies byte offsets 0x20 (event), 0x24 (enable), 0x28 (acknowledge) and 0x2C (raw state). Bank 1 occupies 0x10, 0x14, 0x18 and 0x1C in the same order. Bit i of bank b is source 32*b+i.
- R3: Reading an enable register returns exactly the last value written to it.
- R4: An event bit is set on the clock edge where its input is first sampled high after being low, but only if the source was already enabled before that edge. A rise on a disabled source leaves its event bit at zero.
- R5: Writing an enable bit to 1 while that input is already high sets no event bit and does not assert `irq_req` for an edge-type source.
- R6: Writing 1 to an acknowledge bit clears that event bit on the write edge. Writing 0 leaves it unchanged. A rise latched on the same edge takes precedence.
- R7: The raw-state register reads the current inputs of its bank whatever the enable setting.
- R8: A level-type source (bank 0 mask default 0x1FF00000, bank 1 default 0x3FF00000) is pending whenever its input is high and it is enabled, even after its event bit is acknowledged.
- R9: `irq_req` is high exactly when any source is pending, where pending means (event OR (input AND level mask)) AND enable.
- R10: `top_id` is the highest-numbered pending source, with bank 1 searched before bank 0. When nothing is pending, `top_valid` is low and `top_id` is 0.
- R11: Byte offsets outside the two banks, unaligned offsets, and the acknowledge offsets all read as zero. Writes to unmapped offsets, to event registers and to raw-state registers change nothing.
- R12: Read data appears on `bus_rdata` in the cycle after the read request and is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 64 | Interrupt source inputs, synchronous to clk |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |
| top_valid | output | 1 | A source is pending |
| top_id | output | 6 | Highest-numbered pending source |

## Verification
A write takes effect on the clock edge that samples it. A read answer is due on `bus_rdata` one edge after the request. An input rise is latched on the first edge that sees it high, so `irq_req` and `top_id` for an edge-type source change right after that edge. A level-type source drives them combinationally from its input. The bench drives every input at a falling edge and samples one falling edge later, so exactly one rising edge separates stimulus and check. For the acknowledge and enable cases it reads the event register back over the bus before the next stimulus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 6;

    // high nibble pair of the byte offset selects the bank
    localparam logic [1:0] BANK0_TAG = 2'b10;   // 0x20..0x2C
    localparam logic [1:0] BANK1_TAG = 2'b01;   // 0x10..0x1C

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_RAW    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bank_hit,
    output reg_sel_e          reg_sel,
    output logic [1:0]        en_wr,
    output logic [1:0]        ack_wr,
    output logic              rd_req
);

    logic aligned;

    always_comb begin
        aligned     = (bus_addr[1:0] == 2'b00);
        bank_hit[0] = bus_sel && aligned && (bus_addr[5:4] == BANK0_TAG);
        bank_hit[1] = bus_sel && aligned && (bus_addr[5:4] == BANK1_TAG);
        reg_sel     = reg_sel_e'(bus_addr[3:2]);
        rd_req      = bus_sel && !bus_we;
        for (int b = 0; b < 2; b++) begin
            en_wr[b]  = bank_hit[b] && bus_we && (reg_sel == REG_ENABLE);
            ack_wr[b] = bank_hit[b] && bus_we && (reg_sel == REG_ACK);
        end
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int           W        = 32,
    parameter logic [W-1:0] LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_in,
    input  logic         en_wr,
    input  logic         ack_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] event_q,
    output logic [W-1:0] enable_q,
    output logic [W-1:0] pending
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] ack_bits;

    always_comb begin
        rise     = src_in & ~prev_q;
        ack_bits = ack_wr ? wdata : '0;
        pending  = (event_q | (src_in & LVL_MASK)) & enable_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            enable_q <= '0;
            event_q  <= '0;
        end else begin
            prev_q  <= src_in;
            // old enable gates the rise, so enabling a high input latches nothing
            event_q <= (event_q & ~ack_bits) | (rise & enable_q);
            if (en_wr) begin
                enable_q <= wdata;
            end
        end
    end

    AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (enable_q == $past(wdata)));                                // R3

    AST_NO_EVENT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((event_q & ~$past(event_q) & ~$past(enable_q)) == '0));     // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((event_q & $past(wdata & ~(rise & enable_q))) == '0));     // R6

    AST_ACK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((event_q & $past(~wdata & event_q)) == $past(~wdata & event_q))); // R6

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int W    = 32,
    parameter int ID_W = $clog2(2 * W)
) (
    input  logic [W-1:0]    pend_lo,
    input  logic [W-1:0]    pend_hi,
    output logic            valid,
    output logic [ID_W-1:0] id
);

    localparam int IDX_W = $clog2(W);

    logic [1:0][IDX_W-1:0] top_idx;
    logic [1:0]            any;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_scan
            logic [W-1:0] vec;
            assign vec = (b == 0) ? pend_lo : pend_hi;
            always_comb begin
                top_idx[b] = '0;
                for (int i = 0; i < W; i++) begin
                    if (vec[i]) begin
                        top_idx[b] = IDX_W'(i);
                    end
                end
                any[b] = |vec;
            end
        end
    endgenerate

    always_comb begin
        valid = |any;
        if (any[1]) begin
            id = {1'b1, top_idx[1]};
        end else if (any[0]) begin
            id = {1'b0, top_idx[0]};
        end else begin
            id = '0;
        end
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int                  BANK_W      = 32,
    parameter logic [2*BANK_W-1:0] LEVEL_MASKS = {32'h3ff0_0000, 32'h1ff0_0000}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*BANK_W-1:0]           irq_in,
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BANK_W-1:0]             bus_wdata,
    output logic [BANK_W-1:0]             bus_rdata,
    output logic                          irq_req,
    output logic                          top_valid,
    output logic [$clog2(2*BANK_W)-1:0]   top_id
);

    localparam int SRC_N = 2 * BANK_W;
    localparam int ID_W  = $clog2(SRC_N);

    logic [1:0]        bank_hit;
    reg_sel_e          reg_sel;
    logic [1:0]        en_wr;
    logic [1:0]        ack_wr;
    logic              rd_req;

    logic [1:0][BANK_W-1:0] ev;
    logic [1:0][BANK_W-1:0] en;
    logic [1:0][BANK_W-1:0] pend;

    irqc_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bank_hit (bank_hit),
        .reg_sel  (reg_sel),
        .en_wr    (en_wr),
        .ack_wr   (ack_wr),
        .rd_req   (rd_req)
    );

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            irqc_bank #(
                .W        (BANK_W),
                .LVL_MASK (LEVEL_MASKS[b*BANK_W +: BANK_W])
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_in   (irq_in[b*BANK_W +: BANK_W]),
                .en_wr    (en_wr[b]),
                .ack_wr   (ack_wr[b]),
                .wdata    (bus_wdata),
                .event_q  (ev[b]),
                .enable_q (en[b]),
                .pending  (pend[b])
            );
        end
    endgenerate

    irqc_prio #(
        .W    (BANK_W),
        .ID_W (ID_W)
    ) u_prio (
        .pend_lo (pend[0]),
        .pend_hi (pend[1]),
        .valid   (top_valid),
        .id      (top_id)
    );

    assign irq_req = |{pend[1], pend[0]};

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= '0;
            if (rd_req && (|bank_hit)) begin
                unique case (reg_sel)
                    REG_EVENT:  bus_rdata <= bank_hit[1] ? ev[1] : ev[0];
                    REG_ENABLE: bus_rdata <= bank_hit[1] ? en[1] : en[0];
                    REG_ACK:    bus_rdata <= '0;
                    REG_RAW:    bus_rdata <= bank_hit[1] ? irq_in[BANK_W +: BANK_W]
                                                         : irq_in[0 +: BANK_W];
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

    AST_REQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == top_valid);                                               // R9

    AST_TOP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> pend[top_id[ID_W-1]][top_id[ID_W-2:0]]);               // R10

    AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> (top_id == '0));                                      // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !(|bank_hit)) |=> (bus_rdata == '0));                     // R11

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (bus_rdata == '0));                                      // R12

endmodule

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic [31:0] p1;
        logic [31:0] p0;
        logic [31:0] e1;
        logic [31:0] e0;
        logic        v;
        logic [5:0]  id;
    } vec_t;

    // pattern, enables, expected valid and top source (R10)
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'h0000_0001, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 6'd0},
        '{32'h0000_0000, 32'h8000_0001, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 6'd31},
        '{32'h0000_0001, 32'h8000_0000, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 6'd32},
        '{32'h8000_0000, 32'h0000_0010, 32'h7fff_ffff, 32'hffff_ffff, 1'b1, 6'd4},
        '{32'hc000_0000, 32'h0000_0000, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 6'd63},
        '{32'h0000_0000, 32'h0010_0000, 32'h0000_0000, 32'h0010_0000, 1'b1, 6'd20},
        '{32'h0f0f_0f0f, 32'hf0f0_f0f0, 32'h0000_0000, 32'h0000_0000, 1'b0, 6'd0},
        '{32'h0020_0000, 32'h1000_0000, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 6'd53}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic        top_valid;
    logic [5:0]  top_id;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .top_valid (top_valid),
        .top_id    (top_id)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rdr(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive(input logic [63:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic clean();
        @(negedge clk);
        irq_in = '0;
        wr(6'h28, 32'hffff_ffff);
        wr(6'h18, 32'hffff_ffff);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 top_valid", top_valid, 0);
        chk("R1 rdata", bus_rdata, 0);
        rst_n = 1'b1;
        rdr(6'h24, rd); chk("R1 enable0", rd, 0);
        rdr(6'h10, rd); chk("R1 event1", rd, 0);

        // R3 enable readback, both banks (R2 offsets)
        wr(6'h24, 32'ha5a5_5a5a);
        rdr(6'h24, rd); chk("R3 enable0 readback", rd, 32'ha5a5_5a5a);
        wr(6'h14, 32'h1234_5678);
        rdr(6'h14, rd); chk("R3 enable1 readback", rd, 32'h1234_5678);
        // R12: cycle after a read with no request
        @(negedge clk); chk("R12 idle rdata", bus_rdata, 0);

        // table walk: R9 and R10
        for (int k = 0; k < NVEC; k++) begin
            clean();
            wr(6'h24, VECS[k].e0);
            wr(6'h14, VECS[k].e1);
            drive({VECS[k].p1, VECS[k].p0});
            chk($sformatf("R9 vec%0d irq_req", k), irq_req, VECS[k].v);
            chk($sformatf("R10 vec%0d top_valid", k), top_valid, VECS[k].v);
            chk($sformatf("R10 vec%0d top_id", k), top_id, VECS[k].id);
        end

        // R4 disabled rise ignored
        clean();
        wr(6'h24, 32'h0); wr(6'h14, 32'h0);
        drive(64'h8);
        rdr(6'h20, rd); chk("R4 disabled rise event0", rd, 0);
        // R5 enable while high
        wr(6'h24, 32'h8);
        chk("R5 irq_req after enable high", irq_req, 0);
        rdr(6'h20, rd); chk("R5 event0 after enable high", rd, 0);
        // R4 fresh rise while enabled
        drive(64'h0);
        drive(64'h8);
        chk("R4 irq_req on rise", irq_req, 1);
        chk("R4 top_id on rise", top_id, 3);
        rdr(6'h20, rd); chk("R4 event0 latched", rd, 32'h8);
        // R6 ack of zero keeps, ack of one clears
        wr(6'h28, 32'h0);
        rdr(6'h20, rd); chk("R6 ack zero keeps", rd, 32'h8);
        wr(6'h28, 32'h8);
        rdr(6'h20, rd); chk("R6 ack one clears", rd, 0);
        chk("R6 irq_req after ack", irq_req, 0);

        // R8 level-type source stays pending after ack
        clean();
        wr(6'h24, 32'h0010_0008);
        drive(64'h0010_0008);
        chk("R8 top_id both", top_id, 20);
        wr(6'h28, 32'h0010_0008);
        chk("R8 irq_req level held", irq_req, 1);
        chk("R8 top_id level held", top_id, 20);
        drive(64'h0000_0008);
        chk("R8 irq_req level dropped", irq_req, 0);

        // R7 raw state independent of enable
        clean();
        wr(6'h24, 32'h0); wr(6'h14, 32'h0);
        drive({32'h0bad_cafe, 32'h00f0_000f});
        rdr(6'h2c, rd); chk("R7 raw0", rd, 32'h00f0_000f);
        rdr(6'h1c, rd); chk("R7 raw1", rd, 32'h0bad_cafe);

        // R2 bank 1 mapping: source 33 is bank1 bit1
        clean();
        wr(6'h14, 32'h2);
        drive(64'h2_0000_0000);
        rdr(6'h10, rd); chk("R2 event1 bit1", rd, 32'h2);
        rdr(6'h20, rd); chk("R2 event0 clear", rd, 0);
        chk("R2 top_id 33", top_id, 33);

        // R11 unmapped, read-only and ack offsets
        wr(6'h00, 32'hffff_ffff);
        rdr(6'h00, rd); chk("R11 unmapped 0x00", rd, 0);
        rdr(6'h30, rd); chk("R11 unmapped 0x30", rd, 0);
        rdr(6'h25, rd); chk("R11 unaligned 0x25", rd, 0);
        rdr(6'h18, rd); chk("R11 ack reads zero", rd, 0);
        wr(6'h10, 32'h0);
        rdr(6'h10, rd); chk("R11 event write ignored", rd, 32'h2);
        wr(6'h34, 32'hffff_ffff);
        rdr(6'h14, rd); chk("R11 enable1 untouched", rd, 32'h2);
        wr(6'h2c, 32'hffff_ffff);
        rdr(6'h24, rd); chk("R11 enable0 untouched", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule